// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 12-bit successive-approximation converter. The capacitor array behind it is split into an upper and a lower 6-bit bank. Each bit's capacitor has three bottom-plate controls:
- a sample control that connects the plate to the input,
- an invert control that drives the plate to the opposite reference, and
- a switch control that puts the plate on the trial reference.

The sequencer drives all three from one frame counter and one decision register. It reads a single comparator input, which reports whether the held input is at or above the level the plates currently present.

The sequencer runs with no pause between frames. Each frame is 16 clocks long:
- one sample clock,
- twelve decision clocks, most significant bit first, and
- three closing clocks, one of which copies the decided code into the result register.

The result register has a one-clock valid strobe. The first strobe comes 15 clock edges after reset is released, and a new strobe follows every 16 edges after that. The array, comparator and analog front end are outside the block.

Top module: `sar_seq_top`

## Requirements
- R1: While `rst_n` is low, `result_vld` is 0, `result` is 0, every bit of `cap_sample` is 1, and `cap_invert` and `cap_switch` are 0.
- R2: After `rst_n` rises, `result_vld` stays 0 for the first 14 rising edges. It is 1 during the cycle after the 15th rising edge.
- R3: `result_vld` is high for exactly one cycle per frame. Strobes are exactly 16 cycles apart, without end.
- R4: `result` changes only at the edge that raises `result_vld`. Between strobes it holds its value.
- R5: In frame cycle 0 (the sample cycle), all 12 bits of `cap_sample` are 1 and `cap_invert` and `cap_switch` are 0. In every other cycle, `cap_sample` is 0.
- R6: In frame cycle p, for p from 1 to 12, the trial bit index is 12-p. `cap_switch` equals the already-kept upper bits plus that trial bit, and every bit below the trial bit is 0. The upper bank (bits 11..6) is resolved in cycles 1..6 and the lower bank (bits 5..0) in cycles 7..12.
- R7: At the end of a decision cycle, the trial bit is kept when `cmp_hi` is 1 (input at or above the trial level) and cleared otherwise. With an ideal comparator against an unsigned 12-bit input code, `result` equals that code.
- R8: During decision cycles, `cap_invert` is 1 exactly for bits above the trial bit that were decided 0. No capacitor ever has more than one of sample, invert and switch asserted.
- R9: In frame cycles 13, 14 and 15, `cap_sample`, `cap_invert` and `cap_switch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the trial level |
| cap_sample | output | 12 | Per-capacitor sample control |
| cap_invert | output | 12 | Per-capacitor invert control |
| cap_switch | output | 12 | Per-capacitor switch (trial code) control |
| result | output | 12 | Last completed conversion code |
| result_vld | output | 1 | One-cycle strobe for a new result |

## Verification
The assertions treat `cmp_hi` as a free input. They rely only on it being a defined 0 or 1 at each rising edge, because the frame timing, the control exclusivity and the result hold do not depend on its value.

The bench models the comparator as an ideal unsigned compare of a held stimulus code against `cap_switch`. The stimulus changes only in the sample cycle, so the code stays constant over the twelve decision cycles of a frame. Every 12-bit code is converted once in consecutive frames, and each cycle's controls are predicted from the stimulus bits.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Role of the current clock within a conversion frame.
    typedef enum logic [1:0] {
        FK_SAMPLE = 2'd0,
        FK_DECIDE = 2'd1,
        FK_LATCH  = 2'd2,
        FK_IDLE   = 2'd3
    } frame_kind_e;

endpackage

// File: rtl/sar_phase_ctr.sv
module sar_phase_ctr
    import sar_seq_pkg::*;
#(
    parameter int NBITS     = 12,
    parameter int FRAME_LEN = 16,
    localparam int PH_W     = $clog2(FRAME_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output frame_kind_e     kind
);

    localparam int LATCH_PH = FRAME_LEN - 2;

    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        if (int'(ph_q) == FRAME_LEN - 1) begin
            ph_d = '0;
        end else begin
            ph_d = ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    always_comb begin
        if (ph_q == '0) begin
            kind = FK_SAMPLE;
        end else if (int'(ph_q) <= NBITS) begin
            kind = FK_DECIDE;
        end else if (int'(ph_q) == LATCH_PH) begin
            kind = FK_LATCH;
        end else begin
            kind = FK_IDLE;
        end
    end

    assign phase = ph_q;

endmodule

// File: rtl/sar_trial_dec.sv
module sar_trial_dec
    import sar_seq_pkg::*;
#(
    parameter int NBITS     = 12,
    parameter int FRAME_LEN = 16,
    localparam int PH_W     = $clog2(FRAME_LEN)
) (
    input  logic [PH_W-1:0]  phase,
    input  frame_kind_e      kind,
    output logic [NBITS-1:0] trial_bit,
    output logic [NBITS-1:0] decided
);

    // Decision cycle p tries bit NBITS-p; bits with a higher index are settled.
    always_comb begin
        for (int i = 0; i < NBITS; i++) begin
            trial_bit[i] = (kind == FK_DECIDE) && (int'(phase) + i == NBITS);
            decided[i]   = (kind == FK_DECIDE) && (int'(phase) + i >  NBITS);
        end
    end

endmodule

// File: rtl/sar_bank.sv
module sar_bank #(
    parameter int WIDTH = 6
) (
    input  logic             in_sample,
    input  logic             in_decide,
    input  logic [WIDTH-1:0] kept,
    input  logic [WIDTH-1:0] trial_bit,
    input  logic [WIDTH-1:0] decided,
    output logic [WIDTH-1:0] smp,
    output logic [WIDTH-1:0] inv,
    output logic [WIDTH-1:0] sw
);

    always_comb begin
        smp = {WIDTH{in_sample}};
        sw  = '0;
        inv = '0;
        if (in_decide) begin
            sw  = kept | trial_bit;
            inv = decided & ~kept;
        end
    end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int NBITS     = 12,
    parameter int BANK_BITS = 6,
    parameter int FRAME_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] cap_sample,
    output logic [NBITS-1:0] cap_invert,
    output logic [NBITS-1:0] cap_switch,
    output logic [NBITS-1:0] result,
    output logic             result_vld
);

    localparam int PH_W      = $clog2(FRAME_LEN);
    localparam int NUM_BANKS = NBITS / BANK_BITS;

    typedef struct packed {
        logic [NBITS-1:0] code;
        logic [NBITS-1:0] res;
        logic             vld;
    } sar_state_t;

    logic [PH_W-1:0]  phase;
    frame_kind_e      kind;
    logic [NBITS-1:0] trial_bit;
    logic [NBITS-1:0] decided;
    sar_state_t       st_d, st_q;

    sar_phase_ctr #(
        .NBITS     (NBITS),
        .FRAME_LEN (FRAME_LEN)
    ) u_ph (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .kind  (kind)
    );

    sar_trial_dec #(
        .NBITS     (NBITS),
        .FRAME_LEN (FRAME_LEN)
    ) u_dec (
        .phase     (phase),
        .kind      (kind),
        .trial_bit (trial_bit),
        .decided   (decided)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        case (kind)
            FK_SAMPLE: st_d.code = '0;
            FK_DECIDE: begin
                if (cmp_hi) begin
                    st_d.code = st_q.code | trial_bit;
                end
            end
            FK_LATCH: begin
                st_d.res = st_q.code;
                st_d.vld = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_BITS;
        sar_bank #(
            .WIDTH (BANK_BITS)
        ) u_bank (
            .in_sample (kind == FK_SAMPLE),
            .in_decide (kind == FK_DECIDE),
            .kept      (st_q.code[LO +: BANK_BITS]),
            .trial_bit (trial_bit[LO +: BANK_BITS]),
            .decided   (decided[LO +: BANK_BITS]),
            .smp       (cap_sample[LO +: BANK_BITS]),
            .inv       (cap_invert[LO +: BANK_BITS]),
            .sw        (cap_switch[LO +: BANK_BITS])
        );
    end

    assign result     = st_q.res;
    assign result_vld = st_q.vld;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS     = 12,
    parameter int FRAME_LEN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBITS-1:0] cap_sample,
    input logic [NBITS-1:0] cap_invert,
    input logic [NBITS-1:0] cap_switch,
    input logic [NBITS-1:0] result,
    input logic             result_vld
);

    localparam int GW = $clog2(FRAME_LEN) + 1;

    // Cycles since reset or since the last strobe, saturating.
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (result_vld) begin
            gap_q <= '0;
        end else if (int'(gap_q) < FRAME_LEN) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2, R3: a strobe lands only at the end of a full frame
    a_r3_vld_cadence: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> (int'(gap_q) == FRAME_LEN - 1));

    // R2, R3: the frame end always carries a strobe
    a_r2_vld_not_late: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gap_q) == FRAME_LEN - 1) |-> result_vld);

    // R3
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |=> !result_vld);

    // R4
    a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld |-> $stable(result));

    // R5
    a_r5_sample_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (|cap_sample) |-> ((&cap_sample) && cap_switch == '0 && cap_invert == '0));

    // R8
    for (genvar i = 0; i < NBITS; i++) begin : g_excl
        a_r8_one_control: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({cap_sample[i], cap_invert[i], cap_switch[i]}));
    end

endmodule

bind sar_seq_top sar_seq_chk #(
    .NBITS     (NBITS),
    .FRAME_LEN (FRAME_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_sample (cap_sample),
    .cap_invert (cap_invert),
    .cap_switch (cap_switch),
    .result     (result),
    .result_vld (result_vld)
);

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] stim = '0;
    logic        cmp_hi;
    logic [11:0] cap_sample, cap_invert, cap_switch, result;
    logic        result_vld;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [11:0] last_res = '0;

    always #10 clk = ~clk;

    // Ideal comparator: input code at or above the trial code on the switches.
    assign cmp_hi = (stim >= cap_switch);

    sar_seq_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_hi     (cmp_hi),
        .cap_sample (cap_sample),
        .cap_invert (cap_invert),
        .cap_switch (cap_switch),
        .result     (result),
        .result_vld (result_vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_reset_state();
        chk("R1 vld",    {31'b0, result_vld}, 32'd0);
        chk("R1 result", {20'b0, result},     32'd0);
        chk("R1 sample", {20'b0, cap_sample}, 32'hFFF);
        chk("R1 invert", {20'b0, cap_invert}, 32'd0);
        chk("R1 switch", {20'b0, cap_switch}, 32'd0);
    endtask

    // Checks one cycle p of a frame whose input code is s.
    task automatic chk_cycle(input int p, input logic [11:0] s);
        logic [11:0] e_smp, e_inv, e_sw, upper, trial;
        int idx;
        e_smp = '0; e_inv = '0; e_sw = '0;
        if (p == 0) begin
            e_smp = 12'hFFF;                        // R5
        end else if (p <= 12) begin
            idx   = 12 - p;                         // R6
            trial = 12'(1) << idx;
            upper = ~((trial << 1) - 12'd1);
            e_sw  = (s & upper) | trial;            // R6, R7
            e_inv = ~s & upper;                     // R8
        end                                         // R9 otherwise
        chk("R5 sample",        {20'b0, cap_sample}, {20'b0, e_smp});
        chk("R6 switch",        {20'b0, cap_switch}, {20'b0, e_sw});
        chk("R8 invert",        {20'b0, cap_invert}, {20'b0, e_inv});
        chk("R2 R3 vld timing", {31'b0, result_vld}, {31'b0, (p == 15)});
        if (p == 15) begin
            chk("R7 result code", {20'b0, result}, {20'b0, s});
        end else begin
            chk("R4 result hold", {20'b0, result}, {20'b0, last_res});
        end
    endtask

    task automatic run_frame(input logic [11:0] s);
        stim = s;
        for (int p = 0; p < 16; p++) begin
            chk_cycle(p, s);
            @(negedge clk);
        end
        last_res = s;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk_reset_state();
        rst_n = 1'b1;
        // Exhaustive sweep over every 12-bit input code, frames back to back.
        for (int f = 0; f < 4096; f++) begin
            run_frame(12'(f));
        end
        // Reset in mid-frame, then check the first strobe lands 15 edges after release.
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset_state();
        last_res = '0;
        rst_n = 1'b1;
        run_frame(12'hA5C);
        run_frame(12'h3F0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule